// File: doc/BRIEF.md
# Fast and Normal Interrupt Entry Controller

This block decides, once per instruction boundary, whether the core enters a fast interrupt, a normal interrupt or neither. Two active-low level-sensitive request lines are captured in a register stage, and only these registered values are weighed when the pipeline presents its boundary strobe. The decision applies the current mask flags from the program status, the security state of the core and three configuration bits: one that can make the fast interrupt impossible to mask while nonsecure, and one routing bit per interrupt class that sends entry to the class's own mode or to monitor mode.

When an interrupt is taken, the block issues a one-cycle take pulse and reports the class taken, the target mode, the mask flag values the core must adopt, and a link value. The handler returns by loading the link value less 4 into the PC, which lands on the next instruction that was due to execute. The return rule does not depend on the instruction-set state of the interrupted code. The core feeds the address of the next instruction on `next_pc` and copies the outputs into its status and banked link register.

Top module: `intr_entry_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first boundary, `take` is 0, `tgt_mode` is 00, `take_fiq` is 0, `new_flag_f` and `new_flag_i` are 0, and `link_addr` is 0.
- R2: A request line counts as pending only if it was low at the clock edge before the boundary cycle. A line that goes low during the boundary cycle itself is not seen at that boundary. Results appear at the clock edge that ends the boundary cycle.
- R3: In a cycle with `boundary` low, `take` is 0 at the next edge, and `tgt_mode`, `take_fiq`, `new_flag_f`, `new_flag_i` and `link_addr` keep their values.
- R4: When both classes are pending and eligible at the same boundary, the fast interrupt is taken (`take_fiq`=1).
- R5: A pending fast interrupt is eligible when `flag_f` is 0. A pending normal interrupt is eligible only when `flag_i` is 0. An ineligible request produces no take.
- R6: With `cfg_fiq_lock_n`=0 and `nonsecure`=1, a pending fast interrupt is eligible whatever the value of `flag_f`. In secure state (`nonsecure`=0), `cfg_fiq_lock_n` has no effect.
- R7: Taking a fast interrupt sets `new_flag_f`=1 and `new_flag_i`=1.
- R8: Taking a normal interrupt sets `new_flag_i`=1, and `new_flag_f` equals the `flag_f` input.
- R9: The `tgt_mode` encoding is 00 none, 01 fast-interrupt mode, 10 normal-interrupt mode, 11 monitor mode. A taken class goes to monitor mode when its routing bit (`cfg_fiq_to_mon` or `cfg_irq_to_mon`) is 1, and to its own mode when the bit is 0.
- R10: On a take, `link_addr` = `next_pc` + 4 modulo 2^32, so `link_addr` − 4 equals the `next_pc` presented at the boundary.
- R11: At a boundary where nothing is taken, `take` is 0 and `tgt_mode` is 00, and `take_fiq`, the flag outputs and `link_addr` keep their values.
- R12: `take` is high for exactly the one cycle after each boundary that takes an interrupt. `take_fiq` is 1 for the fast class and 0 for the normal class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fiq_req_n | input | 1 | Fast interrupt request, active low, level |
| irq_req_n | input | 1 | Normal interrupt request, active low, level |
| boundary | input | 1 | End-of-instruction strobe |
| next_pc | input | 32 | Address of the next instruction |
| flag_f | input | 1 | Current fast-interrupt mask flag |
| flag_i | input | 1 | Current normal-interrupt mask flag |
| nonsecure | input | 1 | 1 when the core is in nonsecure state |
| cfg_fiq_lock_n | input | 1 | 0 makes the fast interrupt unmaskable in nonsecure state |
| cfg_fiq_to_mon | input | 1 | 1 routes the fast interrupt to monitor mode |
| cfg_irq_to_mon | input | 1 | 1 routes the normal interrupt to monitor mode |
| take | output | 1 | One-cycle interrupt-entry pulse |
| take_fiq | output | 1 | Class taken: 1 fast, 0 normal |
| tgt_mode | output | 2 | Target mode (00 none, 01 fast, 10 normal, 11 monitor) |
| new_flag_f | output | 1 | Fast mask flag to adopt |
| new_flag_i | output | 1 | Normal mask flag to adopt |
| link_addr | output | 32 | Link value for the handler's return |

## Verification
A wrong pending register or a broken priority chain shows up as a missing or extra `take`, or as the wrong `take_fiq`, at the edge that closes the boundary cycle, one cycle after the stimulus. A bad routing or mask decision appears at the same edge as a wrong `tgt_mode` or flag pair. Held-state faults only become visible on the following idle or empty boundary cycle, as outputs that move when they should keep their values. The stimulus therefore mixes boundaries with idle gaps and with late-arriving request edges, and it checks every output in every cycle.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_FIQ  = 2'b01,
    MODE_IRQ  = 2'b10,
    MODE_MON  = 2'b11
  } entry_mode_e;

  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_FIQ  = 0;
  localparam int unsigned LINE_IRQ  = 1;
endpackage

// File: rtl/intr_rst_sync.sv
module intr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/intr_line_reg.sv
module intr_line_reg #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_n,
  output logic [WIDTH-1:0] pend_q
);
  logic [WIDTH-1:0] pend_d;

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    // active-low level becomes active-high pending
    assign pend_d[g] = ~line_n[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_entry_pkg::*;
(
  input  logic        pend_fiq,
  input  logic        pend_irq,
  input  logic        flag_f,
  input  logic        flag_i,
  input  logic        nonsecure,
  input  logic        cfg_fiq_lock_n,
  input  logic        cfg_fiq_to_mon,
  input  logic        cfg_irq_to_mon,
  output logic        hit,
  output logic        hit_fiq,
  output entry_mode_e hit_mode,
  output logic        hit_f,
  output logic        hit_i
);
  logic fiq_unmaskable;
  logic fiq_elig;
  logic irq_elig;

  always_comb begin
    fiq_unmaskable = nonsecure & ~cfg_fiq_lock_n;
    fiq_elig       = pend_fiq & (~flag_f | fiq_unmaskable);
    irq_elig       = pend_irq & ~flag_i;

    hit      = fiq_elig | irq_elig;
    hit_fiq  = fiq_elig;
    hit_mode = MODE_NONE;
    hit_f    = flag_f;
    hit_i    = flag_i;

    if (fiq_elig) begin
      hit_mode = cfg_fiq_to_mon ? MODE_MON : MODE_FIQ;
      hit_f    = 1'b1;
      hit_i    = 1'b1;
    end else if (irq_elig) begin
      hit_mode = cfg_irq_to_mon ? MODE_MON : MODE_IRQ;
      hit_i    = 1'b1;
    end
  end
endmodule

// File: rtl/intr_entry_regs.sv
module intr_entry_regs
  import intr_entry_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LINK_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              hit,
  input  logic              hit_fiq,
  input  entry_mode_e       hit_mode,
  input  logic              hit_f,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              take_q,
  output logic              fiq_q,
  output entry_mode_e       mode_q,
  output logic              f_q,
  output logic              i_q,
  output logic [ADDR_W-1:0] link_q
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(LINK_OFS);

  logic              take_d;
  logic              fiq_d;
  entry_mode_e       mode_d;
  logic              f_d;
  logic              i_d;
  logic [ADDR_W-1:0] link_d;
  logic              load_en;
  logic              mode_en;

  always_comb begin
    load_en = boundary & hit;
    mode_en = boundary;
    take_d  = load_en;
    mode_d  = hit ? hit_mode : MODE_NONE;
    fiq_d   = hit_fiq;
    f_d     = hit_f;
    i_d     = hit_i;
    link_d  = next_pc + OFS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      mode_q <= MODE_NONE;
      fiq_q  <= 1'b0;
      f_q    <= 1'b0;
      i_q    <= 1'b0;
      link_q <= '0;
    end else begin
      take_q <= take_d;
      if (mode_en) mode_q <= mode_d;
      if (load_en) begin
        fiq_q  <= fiq_d;
        f_q    <= f_d;
        i_q    <= i_d;
        link_q <= link_d;
      end
    end
  end
endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_entry_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINK_OFS   = 4,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fiq_req_n,
  input  logic              irq_req_n,
  input  logic              boundary,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              flag_f,
  input  logic              flag_i,
  input  logic              nonsecure,
  input  logic              cfg_fiq_lock_n,
  input  logic              cfg_fiq_to_mon,
  input  logic              cfg_irq_to_mon,
  output logic              take,
  output logic              take_fiq,
  output logic [1:0]        tgt_mode,
  output logic              new_flag_f,
  output logic              new_flag_i,
  output logic [ADDR_W-1:0] link_addr
);
  logic                 rst_n_s;
  logic [NUM_LINES-1:0] lines_n;
  logic [NUM_LINES-1:0] pend;
  logic                 hit;
  logic                 hit_fiq;
  entry_mode_e          hit_mode;
  logic                 hit_f;
  logic                 hit_i;
  entry_mode_e          mode_q;

  assign lines_n[LINE_FIQ] = fiq_req_n;
  assign lines_n[LINE_IRQ] = irq_req_n;

  intr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  intr_line_reg #(.WIDTH(NUM_LINES)) u_lines (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .line_n (lines_n),
    .pend_q (pend)
  );

  intr_arbiter u_arb (
    .pend_fiq       (pend[LINE_FIQ]),
    .pend_irq       (pend[LINE_IRQ]),
    .flag_f         (flag_f),
    .flag_i         (flag_i),
    .nonsecure      (nonsecure),
    .cfg_fiq_lock_n (cfg_fiq_lock_n),
    .cfg_fiq_to_mon (cfg_fiq_to_mon),
    .cfg_irq_to_mon (cfg_irq_to_mon),
    .hit            (hit),
    .hit_fiq        (hit_fiq),
    .hit_mode       (hit_mode),
    .hit_f          (hit_f),
    .hit_i          (hit_i)
  );

  intr_entry_regs #(.ADDR_W(ADDR_W), .LINK_OFS(LINK_OFS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .boundary (boundary),
    .hit      (hit),
    .hit_fiq  (hit_fiq),
    .hit_mode (hit_mode),
    .hit_f    (hit_f),
    .hit_i    (hit_i),
    .next_pc  (next_pc),
    .take_q   (take),
    .fiq_q    (take_fiq),
    .mode_q   (mode_q),
    .f_q      (new_flag_f),
    .i_q      (new_flag_i),
    .link_q   (link_addr)
  );

  assign tgt_mode = mode_q;
endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              pend_fiq,
  input logic              pend_irq,
  input logic              boundary,
  input logic [ADDR_W-1:0] next_pc,
  input logic              flag_f,
  input logic              flag_i,
  input logic              nonsecure,
  input logic              cfg_fiq_lock_n,
  input logic              cfg_fiq_to_mon,
  input logic              cfg_irq_to_mon,
  input logic              take,
  input logic              take_fiq,
  input logic [1:0]        tgt_mode,
  input logic              new_flag_f,
  input logic              new_flag_i,
  input logic [ADDR_W-1:0] link_addr
);
  logic fiq_ok;
  logic irq_ok;
  assign fiq_ok = pend_fiq & (!flag_f | (nonsecure & !cfg_fiq_lock_n));
  assign irq_ok = pend_irq & !flag_i;

  // R3
  a_r3_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n_s)
    !boundary |=> !take && $stable(tgt_mode) && $stable(link_addr) && $stable(take_fiq));

  // R4 / R6
  a_r4_fiq_first: assert property (@(posedge clk) disable iff (!rst_n_s)
    boundary && fiq_ok |=> take && take_fiq);

  // R7
  a_r7_fiq_masks_both: assert property (@(posedge clk) disable iff (!rst_n_s)
    take && take_fiq |-> new_flag_f && new_flag_i);

  // R8
  a_r8_irq_keeps_f: assert property (@(posedge clk) disable iff (!rst_n_s)
    boundary && !fiq_ok && irq_ok |=> take && !take_fiq && new_flag_i && (new_flag_f == $past(flag_f)));

  // R5 / R11
  a_r11_empty_boundary: assert property (@(posedge clk) disable iff (!rst_n_s)
    boundary && !fiq_ok && !irq_ok |=> !take && (tgt_mode == 2'b00) && $stable(link_addr));

  // R9
  a_r9_fiq_route: assert property (@(posedge clk) disable iff (!rst_n_s)
    boundary && fiq_ok |=> tgt_mode == ($past(cfg_fiq_to_mon) ? 2'b11 : 2'b01));

  // R10
  a_r10_link: assert property (@(posedge clk) disable iff (!rst_n_s)
    boundary && (fiq_ok || irq_ok) |=> link_addr == $past(next_pc) + ADDR_W'(4));

  // R12
  a_r12_take_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    take |-> tgt_mode != 2'b00);
endmodule

bind intr_entry_ctrl intr_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n_s        (rst_n_s),
  .pend_fiq       (pend[0]),
  .pend_irq       (pend[1]),
  .boundary       (boundary),
  .next_pc        (next_pc),
  .flag_f         (flag_f),
  .flag_i         (flag_i),
  .nonsecure      (nonsecure),
  .cfg_fiq_lock_n (cfg_fiq_lock_n),
  .cfg_fiq_to_mon (cfg_fiq_to_mon),
  .cfg_irq_to_mon (cfg_irq_to_mon),
  .take           (take),
  .take_fiq       (take_fiq),
  .tgt_mode       (tgt_mode),
  .new_flag_f     (new_flag_f),
  .new_flag_i     (new_flag_i),
  .link_addr      (link_addr)
);

// File: tb/tb_intr_entry_ctrl.sv
module tb_intr_entry_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fiq_req_n, irq_req_n, boundary;
  logic [31:0] next_pc;
  logic        flag_f, flag_i, nonsecure, cfg_fiq_lock_n, cfg_fiq_to_mon, cfg_irq_to_mon;
  logic        take, take_fiq, new_flag_f, new_flag_i;
  logic [1:0]  tgt_mode;
  logic [31:0] link_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected model state
  logic        e_take, e_fiq, e_f, e_i;
  logic [1:0]  e_mode;
  logic [31:0] e_link;
  logic        pf, pi;  // bench view of pending lines at the last edge

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .fiq_req_n(fiq_req_n), .irq_req_n(irq_req_n),
    .boundary(boundary), .next_pc(next_pc), .flag_f(flag_f), .flag_i(flag_i),
    .nonsecure(nonsecure), .cfg_fiq_lock_n(cfg_fiq_lock_n),
    .cfg_fiq_to_mon(cfg_fiq_to_mon), .cfg_irq_to_mon(cfg_irq_to_mon),
    .take(take), .take_fiq(take_fiq), .tgt_mode(tgt_mode),
    .new_flag_f(new_flag_f), .new_flag_i(new_flag_i), .link_addr(link_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic fiq_elig(input logic p);
    return p & (!flag_f | (nonsecure & !cfg_fiq_lock_n));
  endfunction

  // Called just before the edge: updates the model from current inputs (R2..R12)
  task automatic predict();
    logic ef, ei;
    ef = fiq_elig(pf);
    ei = pi & !flag_i;
    e_take = boundary & (ef | ei);
    if (boundary) begin
      if (ef) begin
        e_fiq = 1'b1; e_f = 1'b1; e_i = 1'b1;
        e_mode = cfg_fiq_to_mon ? 2'b11 : 2'b01;
        e_link = next_pc + 32'd4;
      end else if (ei) begin
        e_fiq = 1'b0; e_f = flag_f; e_i = 1'b1;
        e_mode = cfg_irq_to_mon ? 2'b11 : 2'b10;
        e_link = next_pc + 32'd4;
      end else begin
        e_mode = 2'b00;
      end
    end
    pf = !fiq_req_n;
    pi = !irq_req_n;
  endtask

  task automatic step_check(input string req);
    predict();
    @(posedge clk);
    @(negedge clk);
    chk({req, " take"}, {31'd0, take}, {31'd0, e_take});
    chk({req, " mode"}, {30'd0, tgt_mode}, {30'd0, e_mode});
    chk({req, " class"}, {31'd0, take_fiq}, {31'd0, e_fiq});
    chk({req, " flags"}, {30'd0, new_flag_f, new_flag_i}, {30'd0, e_f, e_i});
    chk({req, " link"}, link_addr, e_link);
  endtask

  task automatic set_in(input logic fn, input logic in_n, input logic b, input logic [31:0] pc,
                        input logic ff, input logic fi, input logic ns, input logic lk,
                        input logic fm, input logic im);
    fiq_req_n = fn; irq_req_n = in_n; boundary = b; next_pc = pc;
    flag_f = ff; flag_i = fi; nonsecure = ns; cfg_fiq_lock_n = lk;
    cfg_fiq_to_mon = fm; cfg_irq_to_mon = im;
  endtask

  // present lines for one edge, then a boundary with the same lines
  task automatic trial(input string req, input logic fn, input logic in_n, input logic [31:0] pc,
                       input logic ff, input logic fi, input logic ns, input logic lk,
                       input logic fm, input logic im);
    set_in(fn, in_n, 1'b0, pc, ff, fi, ns, lk, fm, im);
    step_check(req);
    boundary = 1'b1;
    step_check(req);
    boundary = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    set_in(1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    e_take = 0; e_fiq = 0; e_f = 0; e_i = 0; e_mode = 0; e_link = 0; pf = 0; pi = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, lines held low must not leak through
    fiq_req_n = 1'b0;
    @(negedge clk);
    chk("R1 take", {31'd0, take}, 32'd0);
    chk("R1 mode", {30'd0, tgt_mode}, 32'd0);
    chk("R1 link", link_addr, 32'd0);
    chk("R1 flags", {30'd0, new_flag_f, new_flag_i}, 32'd0);
    fiq_req_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pf = 0; pi = 0;
    step_check("R1 post-reset idle");

    // R4: both pending and eligible
    trial("R4 fiq over irq", 1'b0, 1'b0, 32'h0000_1000, 0, 0, 0, 1, 0, 0);
    // R3: idle cycle with changed pc, outputs hold
    set_in(1'b0, 1'b0, 1'b0, 32'h0000_2222, 0, 0, 0, 1, 0, 0);
    step_check("R3 hold");
    // R8: irq only, F=1 passes through
    trial("R8 irq F passthrough", 1'b1, 1'b0, 32'h0000_3000, 1, 0, 0, 1, 0, 0);
    // R5: F masks fiq in secure state with lock active
    trial("R5 fiq masked", 1'b0, 1'b1, 32'h0000_4000, 1, 0, 0, 0, 0, 0);
    // R6: nonsecure + lock_n=0: fiq taken despite F
    trial("R6 fiq unmaskable", 1'b0, 1'b1, 32'h0000_5000, 1, 1, 1, 0, 1, 0);
    // R6: lock bit=1 in nonsecure does nothing
    trial("R6 lock off", 1'b0, 1'b1, 32'h0000_6000, 1, 1, 1, 1, 0, 0);
    // R5: I masks irq
    trial("R5 irq masked", 1'b1, 1'b0, 32'h0000_7000, 0, 1, 0, 1, 0, 0);
    // R9: irq to monitor
    trial("R9 irq monitor", 1'b1, 1'b0, 32'h0000_8000, 0, 0, 0, 1, 0, 1);
    // R10: wrap of link value
    trial("R10 link wrap", 1'b0, 1'b1, 32'hFFFF_FFFE, 0, 0, 0, 1, 0, 0);
    // R2: line falls in the boundary cycle itself: not seen
    set_in(1'b1, 1'b1, 1'b0, 32'h0000_9000, 0, 0, 0, 1, 0, 0);
    step_check("R2 setup");
    fiq_req_n = 1'b0; irq_req_n = 1'b0; boundary = 1'b1;
    step_check("R2 late edge");
    boundary = 1'b0;
    // R12: pulse lasts one cycle
    set_in(1'b1, 1'b1, 1'b0, 32'h0000_A000, 0, 0, 0, 1, 0, 0);
    step_check("R12 pulse end");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      set_in(r[0], r[1], r[2] | r[3], {$urandom} & 32'hFFFF_FFFE, r[4], r[5], r[6], r[7],
             r[8], r[9]);
      step_check("R12 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule